// File: doc/BRIEF.md
# Push-button PWM brightness controller

The block produces a pulse-width modulated output whose duty value is trimmed up or down by a push button. The raw button is active-low and noisy. It is inverted and passed through a synchronizer, then through a debounce state machine. The debouncer gives two outputs: a settled level and a one-clock pulse that marks an accepted press.

Each rising edge of the settled level applies one step to an 8-bit duty register. A direction input selects the sign of the step, and a 4-bit switch field sets its size. The duty value saturates at both ends and does not wrap. An 8-bit free-running counter compares against the duty value to form the PWM waveform, which has a period of 256 clocks. The output is typically used to strobe the enables of LED drivers, so the duty value sets the brightness.

Top module: `btn_pwm_ctrl`

## Requirements
- R1: On a rising clock edge with `rst_n` low, all state is cleared, so `pwm_o`, `db_level` and `db_pulse` read 0. The duty register loads `DUTY_INIT` (default 128). Reset is synchronous.
- R2: `btn_n` is active-low (0 means pressed). It is inverted, then passed through a two-stage synchronizer before the debouncer sees it.
- R3: `db_level` changes state only after the synchronized button has held the opposite value for `SETTLE_CYC`+1 consecutive clock edges. Any return to the current level before then restarts the count.
- R4: `db_pulse` is high for exactly one clock, in the same cycle in which `db_level` rises. A release never produces a pulse.
- R5: The duty step is 8 bits wide:
  - bit 1 = NOT `step_sw[0]`
  - bit 2 = NOT `step_sw[1]`
  - bit 3 = NOT `step_sw[2]`
  - bit 4 = `step_sw[3]`
  - bits 0, 5, 6 and 7 = 0

  For example, `step_sw`=0000 gives 14, 1000 gives 30, 0111 gives 0 and 1111 gives 16.
- R6: One clock after `db_level` rises, the duty value changes by one step. The step is added when `raise`=1 and subtracted when `raise`=0. A press that is held applies only one step.
- R7: The duty value saturates: additions stop at 255 and subtractions stop at 0.
- R8: An 8-bit counter runs freely from 0 after reset. `pwm_o` is a register loaded each clock with (counter < duty). Over any 256 consecutive clocks with a stable duty D, `pwm_o` is therefore high for D clocks.
- R9: The debounce states are Gray-coded, so every state transition flips at most one state bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| btn_n | input | 1 | Raw push button, active low, asynchronous |
| raise | input | 1 | Step direction: 1 adds (brighter), 0 subtracts (dimmer) |
| step_sw | input | 4 | Switch field that forms the step size |
| pwm_o | output | 1 | PWM output |
| db_level | output | 1 | Debounced button level |
| db_pulse | output | 1 | One-clock pulse on an accepted press |

## Verification
The assertions check several properties on every cycle:
- Each debounce state change flips at most one bit.
- The pulse coincides with a rising level and never lasts two clocks.
- The duty register moves only on the clock after a level rise, and only in the direction given by `raise`.
- A zero duty keeps the output low.

Some behaviours only the bench scenarios can show. These are the exact settle time and the restart on bounce, the step values decoded from the switches, the single step per long hold, and saturation at both ends. The bench observes them through the measured high time of whole PWM periods and through a cycle-accurate reference model.

// File: rtl/btn_pwm_pkg.sv
package btn_pwm_pkg;

    localparam int DUTY_W = 8;
    localparam int SW_W   = 4;

    typedef logic [DUTY_W-1:0] duty_t;

    // Gray-ordered ring: IDLE -> RISE -> HELD -> FALL -> IDLE
    typedef enum logic [1:0] {
        DB_IDLE = 2'b00,
        DB_RISE = 2'b01,
        DB_HELD = 2'b11,
        DB_FALL = 2'b10
    } db_state_e;

    typedef struct packed {
        logic level;
        logic pulse;
    } db_out_t;

    // Switch field to step: bits 1..3 inverted, bit 4 straight, rest zero
    function automatic duty_t step_from_sw(input logic [SW_W-1:0] sw);
        duty_t s;
        s    = '0;
        s[1] = ~sw[0];
        s[2] = ~sw[1];
        s[3] = ~sw[2];
        s[4] =  sw[3];
        return s;
    endfunction

    function automatic duty_t sat_adjust(input duty_t cur, input duty_t step, input logic up);
        logic [DUTY_W:0] wide;
        if (up) begin
            wide = {1'b0, cur} + {1'b0, step};
            return wide[DUTY_W] ? {DUTY_W{1'b1}} : wide[DUTY_W-1:0];
        end
        return (step > cur) ? '0 : cur - step;
    endfunction

endpackage

// File: rtl/btn_debounce.sv
module btn_debounce
    import btn_pwm_pkg::*;
#(
    parameter int SETTLE_CYC  = 1950000,
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    press,
    output db_out_t dbo
);
    localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   s;
    db_state_e              state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   pulse_q;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], press};
    end

    assign s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DB_IDLE;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (state_q)
                DB_IDLE: if (s) begin
                    state_q <= DB_RISE;
                    cnt_q   <= '0;
                end
                DB_RISE: begin
                    if (!s) begin
                        state_q <= DB_IDLE;
                    end else if (cnt_q == LAST) begin
                        state_q <= DB_HELD;
                        pulse_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                DB_HELD: if (!s) begin
                    state_q <= DB_FALL;
                    cnt_q   <= '0;
                end
                DB_FALL: begin
                    if (s) begin
                        state_q <= DB_HELD;
                    end else if (cnt_q == LAST) begin
                        state_q <= DB_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= DB_IDLE;
            endcase
        end
    end

    // HELD and FALL share the high bit: the level is that bit
    assign dbo.level = state_q[1];
    assign dbo.pulse = pulse_q;

endmodule

// File: rtl/duty_adjust.sv
module duty_adjust
    import btn_pwm_pkg::*;
#(
    parameter int DUTY_INIT = 128
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  level,
    input  logic  up,
    input  duty_t step,
    output duty_t duty
);
    logic  level_d;
    duty_t duty_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_d <= 1'b0;
            duty_q  <= duty_t'(DUTY_INIT);
        end else begin
            level_d <= level;
            if (level && !level_d)
                duty_q <= sat_adjust(duty_q, step, up);
        end
    end

    assign duty = duty_q;

endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
    import btn_pwm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  duty_t duty,
    output logic  pwm
);
    duty_t cnt_q;
    logic  pwm_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= (cnt_q < duty);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign pwm = pwm_q;

endmodule

// File: rtl/btn_pwm_ctrl.sv
module btn_pwm_ctrl
    import btn_pwm_pkg::*;
#(
    parameter int SETTLE_CYC  = 1950000,
    parameter int SYNC_STAGES = 2,
    parameter int DUTY_INIT   = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            btn_n,
    input  logic            raise,
    input  logic [SW_W-1:0] step_sw,
    output logic            pwm_o,
    output logic            db_level,
    output logic            db_pulse
);
    db_out_t dbo;
    duty_t   step;
    duty_t   duty_q;

    assign step = step_from_sw(step_sw);

    btn_debounce #(
        .SETTLE_CYC (SETTLE_CYC),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_db (
        .clk  (clk),
        .rst_n(rst_n),
        .press(~btn_n),
        .dbo  (dbo)
    );

    duty_adjust #(
        .DUTY_INIT(DUTY_INIT)
    ) u_duty (
        .clk  (clk),
        .rst_n(rst_n),
        .level(dbo.level),
        .up   (raise),
        .step (step),
        .duty (duty_q)
    );

    pwm_gen u_pwm (
        .clk  (clk),
        .rst_n(rst_n),
        .duty (duty_q),
        .pwm  (pwm_o)
    );

    assign db_level = dbo.level;
    assign db_pulse = dbo.pulse;

endmodule

// File: rtl/btn_pwm_chk.sv
module btn_pwm_chk
    import btn_pwm_pkg::*;
(
    input logic  clk,
    input logic  rst_n,
    input logic  raise,
    input logic  pwm_o,
    input logic  db_level,
    input logic  db_pulse,
    input duty_t duty_q
);
    // R4
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_pulse |-> $rose(db_level));

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_pulse |=> !db_pulse);

    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(db_level && !$past(db_level)) |=> $stable(duty_q));

    // R6
    duty_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(db_level) |=> (raise ? (duty_q >= $past(duty_q)) : (duty_q <= $past(duty_q))));

    // R8
    zero_duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_q == '0) |=> !pwm_o);
endmodule

module db_gray_chk
    import btn_pwm_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input db_state_e st
);
    // R9
    gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st ^ $past(st)) <= 1);
endmodule

bind btn_pwm_ctrl btn_pwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .raise   (raise),
    .pwm_o   (pwm_o),
    .db_level(db_level),
    .db_pulse(db_pulse),
    .duty_q  (duty_q)
);

bind btn_debounce db_gray_chk u_gchk (
    .clk  (clk),
    .rst_n(rst_n),
    .st   (state_q)
);

// File: tb/sim_btn_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_btn_pwm_ctrl;
    localparam int SETTLE = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       btn_n = 1'b1;
    logic       raise = 1'b0;
    logic [3:0] step_sw = 4'b0000;
    logic       pwm_o, db_level, db_pulse;

    int total = 0;
    int bad = 0;
    bit started = 0;
    bit done = 0;

    always #2 clk = ~clk;

    btn_pwm_ctrl #(.SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .raise(raise),
        .step_sw(step_sw), .pwm_o(pwm_o), .db_level(db_level), .db_pulse(db_pulse)
    );

    // behavioural reference
    bit m_p1, m_p2, m_lvl, m_lvld, m_pulse, m_pwm;
    int m_run, m_duty, m_cnt;

    function automatic int step_of(input logic [3:0] sw);   // R5
        return (sw[0] ? 0 : 2) + (sw[1] ? 0 : 4) + (sw[2] ? 0 : 8) + (sw[3] ? 16 : 0);
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_p1 = 0; m_p2 = 0; m_run = 0; m_lvl = 0; m_lvld = 0;
            m_pulse = 0; m_duty = 128; m_cnt = 0; m_pwm = 0;
        end else begin
            bit s, ol, old;
            int od, oc, nd;
            s = m_p2; m_p2 = m_p1; m_p1 = !btn_n;
            ol = m_lvl; old = m_lvld; od = m_duty; oc = m_cnt;
            m_pwm = (oc < od);
            m_cnt = (oc + 1) % 256;
            if (ol && !old) begin
                nd = raise ? od + step_of(step_sw) : od - step_of(step_sw);
                m_duty = (nd > 255) ? 255 : ((nd < 0) ? 0 : nd);
            end
            m_lvld = ol;
            m_pulse = 0;
            if (s != m_lvl) begin
                m_run++;
                if (m_run == SETTLE + 1) begin
                    m_lvl = s; m_run = 0; m_pulse = s;
                end
            end else m_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (started && !done) begin
        chk(pwm_o == m_pwm, "R8 pwm_o", pwm_o, m_pwm);
        chk(db_level == m_lvl, "R3 db_level", db_level, m_lvl);
        chk(db_pulse == m_pulse, "R4 db_pulse", db_pulse, m_pulse);
    end

    int pulses;
    always @(negedge clk) if (db_pulse) pulses++;

    task automatic press(input int hold);
        int p0;
        p0 = pulses;
        @(negedge clk) btn_n = 1'b0;
        repeat (hold) @(negedge clk);
        btn_n = 1'b1;
        repeat (SETTLE + 10) @(negedge clk);
        chk(pulses - p0 == 1, "R4 one pulse per press", pulses - p0, 1);
    endtask

    task automatic measure(input int exp, input string req);
        int hi;
        hi = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (pwm_o) hi++;
        end
        chk(hi == exp, req, hi, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(pwm_o == 0 && db_level == 0 && db_pulse == 0, "R1 reset outputs", {pwm_o, db_level, db_pulse}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        measure(128, "R1 R8 initial duty");

        raise = 0; step_sw = 4'b0000;            // step 14
        press(SETTLE + 10);
        measure(114, "R5 R6 R2 subtract 14");

        press(200);                              // long hold: one step
        measure(100, "R6 held press single step");

        begin : bounce_blk
            int p0;
            p0 = pulses;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk) btn_n = 1'b0;
                repeat (SETTLE / 2) @(negedge clk);
                btn_n = 1'b1;
                repeat (3) @(negedge clk);
            end
            repeat (SETTLE + 5) @(negedge clk);
            chk(pulses == p0, "R3 bounce rejected pulses", pulses - p0, 0);
            chk(db_level == 0, "R3 bounce level", db_level, 0);
        end
        measure(100, "R3 bounce leaves duty");

        raise = 1; step_sw = 4'b1000;            // step 30
        press(SETTLE + 10);
        measure(130, "R5 R6 add 30");

        step_sw = 4'b0111;                       // step 0
        press(SETTLE + 10);
        measure(130, "R5 zero step");

        step_sw = 4'b1111;                       // step 16
        for (int k = 0; k < 9; k++) press(SETTLE + 5);
        measure(255, "R7 saturate high");

        raise = 0; step_sw = 4'b1000;            // step 30
        for (int k = 0; k < 10; k++) press(SETTLE + 5);
        measure(0, "R7 R8 saturate low");

        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pwm_o == 0 && db_level == 0, "R1 mid-run reset", {pwm_o, db_level}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        measure(128, "R1 duty reloaded");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule